// File: doc/BRIEF.md
# Flash Rewrite Mode Control Registers

This block holds the registers that let software enter a CPU-driven flash rewrite mode. It sits on a byte-wide peripheral bus with an address, a write strobe, a read strobe, write data and combinational read data. The flash array, the command decoder and the program/erase timing are outside this block. They reach it only as a busy level, a done pulse with an error flag, a suspend request and an 8-bit command status byte.

Two control bits, rewrite enable and mode select, can only be set through a write-zero-then-write-one arming sequence. Mode select can be set only once enable is already on. With enable on and mode select at 0, the CPU keeps running and polls the status byte. With both bits on, the status byte is hidden, and a stall output holds the CPU for the duration of a program or erase. A read-only identification register returns the flash module type code only right after a write of FFh to it.

Top module: `flash_rewrite_ctl`

## Requirements
- R1: After reset, the control register reads 00h, the identification register reads 00h, and both stall_o and mode_b_o are 0.
- R2: Control bit 0 (enable) becomes 1 only on a control write with bit 0 = 1 when the previous control write had bit 0 = 0. A write of 1 without that arming leaves the bit at 0. A control write with bit 0 = 0 always clears it.
- R3: Control bit 1 (mode select) becomes 1 only on a control write with bits 1 and 0 both 1. That write must find enable already 1 and mode select armed by an earlier control write with bit 1 = 0. Otherwise it stays 0, so it is never 1 while enable is 0.
- R4: A write to any address other than the control register (address 0) disarms both control bits, so the next write of 1 is ignored.
- R5: Reading address 1 returns stat_i when mode B (enable and mode select both 1) is not active, and 00h while mode B is active. mode_b_o reports mode B.
- R6: In mode B, stall_o rises at the first clock edge that samples busy_i high after it was low. In mode A, stall_o stays 0.
- R7: While stall_o is 1, it falls at the clock edge that samples done_i or susp_i high.
- R8: Control bits 2..5 read busy_i, last-op-ok, last-op-error and stall_o. A done_i pulse sets ok to !err_i and error to err_i. A new rise of busy_i clears both.
- R9: A control write that clears enable (bit 0 = 0) also clears mode select, mode_b_o and stall_o at that same edge.
- R10: The identification register (address 2) reads {6'b0, MODULE_TYPE} only after a write of FFh to it, with no access to another address since. Any other write value, or any access elsewhere, makes it read 00h.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| addr_i | input | ADDR_W | Register address |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data, 0 when rd_i is low |
| stat_i | input | 8 | Command status byte from the command decoder |
| busy_i | input | 1 | Program or erase in progress |
| done_i | input | 1 | Operation finished pulse |
| err_i | input | 1 | Error flag, valid with done_i |
| susp_i | input | 1 | Erase-suspend request |
| mode_b_o | output | 1 | Stalling mode active |
| stall_o | output | 1 | CPU stall request |

## Verification
The bench builds the block with its default 2-bit address map and with MODULE_TYPE set to 2'b11. This shows that the identification readback follows the parameter and is not a fixed constant. With the default addresses, control, status, identification and one unused location can all be reached, so disarming through a write to a different address is exercised with both the status and the identification addresses.

// File: rtl/fr_pkg.sv
package fr_pkg;
    localparam int DATA_W     = 8;
    localparam int CTRL_REN   = 0;
    localparam int CTRL_MSEL  = 1;
    localparam int CTRL_BUSY  = 2;
    localparam int CTRL_OK    = 3;
    localparam int CTRL_ERR   = 4;
    localparam int CTRL_STALL = 5;
    localparam int CTRL_USED  = 6;

    typedef struct packed {
        logic ren;
        logic msel;
        logic ren_arm;
        logic msel_arm;
    } ctrl_st_t;

    typedef struct packed {
        logic stall;
        logic busy_prev;
        logic ok;
        logic err;
    } trk_st_t;

    typedef struct packed {
        logic armed;
    } id_st_t;
endpackage

// File: rtl/fr_ctrl_regs.sv
module fr_ctrl_regs
    import fr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic wr_ctrl_i,
    input  logic wr_other_i,
    input  logic wen_bit_i,
    input  logic wmsel_bit_i,
    output logic ren_o,
    output logic msel_o
);
    ctrl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_ctrl_i) begin
            if (!wen_bit_i) begin
                st_d.ren     = 1'b0;
                st_d.msel    = 1'b0;
                st_d.ren_arm = 1'b1;
            end else begin
                if (st_q.ren_arm) st_d.ren = 1'b1;
                st_d.ren_arm = 1'b0;
            end
            if (!wmsel_bit_i) begin
                st_d.msel     = 1'b0;
                st_d.msel_arm = 1'b1;
            end else begin
                if (st_q.msel_arm && st_q.ren && wen_bit_i) st_d.msel = 1'b1;
                st_d.msel_arm = 1'b0;
            end
        end else if (wr_other_i) begin
            st_d.ren_arm  = 1'b0;
            st_d.msel_arm = 1'b0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign ren_o  = st_q.ren;
    assign msel_o = st_q.msel;
endmodule

// File: rtl/fr_op_track.sv
module fr_op_track
    import fr_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic mode_b_i,
    input  logic exit_b_i,
    input  logic busy_i,
    input  logic done_i,
    input  logic err_i,
    input  logic susp_i,
    output logic stall_o,
    output logic ok_o,
    output logic err_o
);
    trk_st_t st_d, st_q;
    logic    start;

    always_comb begin
        st_d           = st_q;
        st_d.busy_prev = busy_i;
        start          = busy_i && !st_q.busy_prev;
        if (start) begin
            st_d.ok  = 1'b0;
            st_d.err = 1'b0;
        end
        if (done_i) begin
            st_d.ok  = !err_i;
            st_d.err = err_i;
        end
        if (done_i || susp_i || exit_b_i || !mode_b_i) st_d.stall = 1'b0;
        else if (start)                                st_d.stall = 1'b1;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign stall_o = st_q.stall;
    assign ok_o    = st_q.ok;
    assign err_o   = st_q.err;
endmodule

// File: rtl/fr_id_reg.sv
module fr_id_reg
    import fr_pkg::*;
#(
    parameter logic [1:0] MODULE_TYPE = 2'b10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_id_i,
    input  logic              other_acc_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [1:0]        id_o
);
    localparam logic [DATA_W-1:0] ID_KEY = '1;
    id_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_id_i)          st_d.armed = (wdata_i == ID_KEY);
        else if (other_acc_i) st_d.armed = 1'b0;
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign id_o = st_q.armed ? MODULE_TYPE : 2'b00;
endmodule

// File: rtl/flash_rewrite_ctl.sv
module flash_rewrite_ctl
    import fr_pkg::*;
#(
    parameter int                ADDR_W      = 2,
    parameter logic [ADDR_W-1:0] ADDR_CTRL   = 2'd0,
    parameter logic [ADDR_W-1:0] ADDR_STAT   = 2'd1,
    parameter logic [ADDR_W-1:0] ADDR_ID     = 2'd2,
    parameter logic [1:0]        MODULE_TYPE = 2'b10
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    input  logic [DATA_W-1:0] stat_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              err_i,
    input  logic              susp_i,
    output logic              mode_b_o,
    output logic              stall_o
);
    localparam int PAD_W = DATA_W - CTRL_USED;

    logic wr_ctrl, wr_other, wr_id, other_acc, exit_b;
    logic ren, msel, ok, err, stall;
    logic [1:0] id_bits;
    logic [DATA_W-1:0] rd_val;

    assign wr_ctrl   = wr_i && (addr_i == ADDR_CTRL);
    assign wr_other  = wr_i && (addr_i != ADDR_CTRL);
    assign wr_id     = wr_i && (addr_i == ADDR_ID);
    assign other_acc = (wr_i || rd_i) && (addr_i != ADDR_ID);
    assign exit_b    = wr_ctrl && (!wdata_i[CTRL_REN] || !wdata_i[CTRL_MSEL]);

    fr_ctrl_regs u_ctrl (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_ctrl_i   (wr_ctrl),
        .wr_other_i  (wr_other),
        .wen_bit_i   (wdata_i[CTRL_REN]),
        .wmsel_bit_i (wdata_i[CTRL_MSEL]),
        .ren_o       (ren),
        .msel_o      (msel)
    );

    fr_op_track u_trk (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .mode_b_i (ren && msel),
        .exit_b_i (exit_b),
        .busy_i   (busy_i),
        .done_i   (done_i),
        .err_i    (err_i),
        .susp_i   (susp_i),
        .stall_o  (stall),
        .ok_o     (ok),
        .err_o    (err)
    );

    fr_id_reg #(.MODULE_TYPE(MODULE_TYPE)) u_id (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .wr_id_i     (wr_id),
        .other_acc_i (other_acc),
        .wdata_i     (wdata_i),
        .id_o        (id_bits)
    );

    always_comb begin
        rd_val = '0;
        if (addr_i == ADDR_CTRL) begin
            rd_val = {{PAD_W{1'b0}}, stall, err, ok, busy_i, msel, ren};
        end else if (addr_i == ADDR_STAT) begin
            rd_val = (ren && msel) ? '0 : stat_i;
        end else if (addr_i == ADDR_ID) begin
            rd_val = {{(DATA_W-2){1'b0}}, id_bits};
        end
    end

    assign rdata_o  = rd_i ? rd_val : '0;
    assign mode_b_o = ren && msel;
    assign stall_o  = stall;
endmodule

// File: rtl/fr_chk.sv
module fr_chk #(
    parameter int                ADDR_W    = 2,
    parameter logic [ADDR_W-1:0] ADDR_CTRL = 2'd0,
    parameter logic [ADDR_W-1:0] ADDR_STAT = 2'd1
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic [ADDR_W-1:0] addr_i,
    input logic              wr_i,
    input logic              rd_i,
    input logic [7:0]        wdata_i,
    input logic [7:0]        rdata_o,
    input logic              done_i,
    input logic              susp_i,
    input logic              mode_b_o,
    input logic              stall_o,
    input logic              ren,
    input logic              msel
);
    // R3
    msel_needs_ren_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(msel && !ren));

    // R2
    ren_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(ren) |-> $past(wr_i && addr_i == ADDR_CTRL && wdata_i[0]));

    // R6
    stall_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        stall_o |-> mode_b_o);

    // R7
    stall_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (stall_o && (done_i || susp_i)) |=> !stall_o);

    // R9
    exit_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_i && addr_i == ADDR_CTRL && !wdata_i[0]) |=> (!mode_b_o && !stall_o));

    // R5
    stat_mask_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && addr_i == ADDR_STAT && mode_b_o) |-> (rdata_o == 8'h00));
endmodule

bind flash_rewrite_ctl fr_chk #(
    .ADDR_W    (ADDR_W),
    .ADDR_CTRL (ADDR_CTRL),
    .ADDR_STAT (ADDR_STAT)
) u_fr_chk (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .addr_i   (addr_i),
    .wr_i     (wr_i),
    .rd_i     (rd_i),
    .wdata_i  (wdata_i),
    .rdata_o  (rdata_o),
    .done_i   (done_i),
    .susp_i   (susp_i),
    .mode_b_o (mode_b_o),
    .stall_o  (stall_o),
    .ren      (ren),
    .msel     (msel)
);

// File: tb/flash_rewrite_ctl_bench.sv
`timescale 1ns/1ps
module flash_rewrite_ctl_bench;
    logic       clk = 1'b0;
    logic       rst_ni = 1'b0;
    logic [1:0] addr = '0;
    logic       wr = 1'b0, rd = 1'b0;
    logic [7:0] wdata = '0, rdata, stat = 8'hA5;
    logic       busy = 0, done = 0, err = 0, susp = 0;
    logic       mode_b, stall;
    int         checks = 0, errors = 0;

    always #2.5 clk = ~clk;

    flash_rewrite_ctl #(.MODULE_TYPE(2'b11)) u_flash_rewrite_ctl (
        .clk_i(clk), .rst_ni(rst_ni), .addr_i(addr), .wr_i(wr), .rd_i(rd),
        .wdata_i(wdata), .rdata_o(rdata), .stat_i(stat), .busy_i(busy),
        .done_i(done), .err_i(err), .susp_i(susp), .mode_b_o(mode_b),
        .stall_o(stall)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk); rst_ni = 0; busy = 0; done = 0; err = 0; susp = 0;
        @(negedge clk); @(negedge clk); rst_ni = 1;
    endtask

    task automatic bus_wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); addr = a; wdata = d; wr = 1;
        @(negedge clk); wr = 0;
    endtask

    task automatic bus_rd(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk); addr = a; rd = 1; #1 d = rdata;
        @(negedge clk); rd = 0;
    endtask

    task automatic enter_b();
        bus_wr(0, 8'h00); bus_wr(0, 8'h01); bus_wr(0, 8'h03);
    endtask

    task automatic t_reset();
        logic [7:0] v;
        do_reset();
        bus_rd(0, v); chk("R1 ctrl", v, 8'h00);
        bus_rd(2, v); chk("R1 id", v, 8'h00);
        chk("R1 stall/mode", {6'b0, stall, mode_b}, 8'h00);
    endtask

    task automatic t_arming();
        logic [7:0] v;
        do_reset();
        bus_wr(0, 8'h01); bus_rd(0, v); chk("R2 unarmed write of 1", v, 8'h00);
        bus_wr(0, 8'h00); bus_wr(0, 8'h01); bus_rd(0, v); chk("R2 armed enable", v, 8'h01);
        bus_wr(0, 8'h00); bus_rd(0, v); chk("R2 clear", v, 8'h00);
        bus_wr(0, 8'h02); bus_rd(0, v); chk("R3 msel without enable", v, 8'h00);
        bus_wr(0, 8'h00); bus_wr(0, 8'h03); bus_rd(0, v); chk("R3 same-write msel", v, 8'h01);
        bus_wr(0, 8'h01); bus_wr(0, 8'h03); bus_rd(0, v); chk("R3 mode B entry", v, 8'h03);
        chk("R5 mode_b_o", {7'b0, mode_b}, 8'h01);
    endtask

    task automatic t_disarm();
        logic [7:0] v;
        do_reset();
        bus_wr(0, 8'h00); bus_wr(1, 8'h00); bus_wr(0, 8'h01);
        bus_rd(0, v); chk("R4 disarm by status write", v, 8'h00);
        bus_wr(0, 8'h00); bus_wr(0, 8'h01); bus_wr(2, 8'h12); bus_wr(0, 8'h03);
        bus_rd(0, v); chk("R4 msel disarmed by id write", v, 8'h01);
    endtask

    task automatic t_status();
        logic [7:0] v;
        do_reset();
        bus_wr(0, 8'h00); bus_wr(0, 8'h01);
        bus_rd(1, v); chk("R5 status in mode A", v, 8'hA5);
        bus_wr(0, 8'h03);
        bus_rd(1, v); chk("R5 status masked in mode B", v, 8'h00);
    endtask

    task automatic t_stall();
        logic [7:0] v;
        do_reset(); enter_b();
        @(negedge clk); busy = 1;
        @(posedge clk); #1 chk("R6 stall rises", {7'b0, stall}, 8'h01);
        @(negedge clk); @(negedge clk);
        chk("R6 stall holds", {7'b0, stall}, 8'h01);
        bus_rd(0, v); chk("R8 ctrl during op", v, 8'h27);
        @(negedge clk); done = 1; busy = 0;
        @(posedge clk); #1 chk("R7 drop on done", {7'b0, stall}, 8'h00);
        @(negedge clk); done = 0;
        bus_rd(0, v); chk("R8 ok after done", v, 8'h0B);
        @(negedge clk); busy = 1;
        @(negedge clk); susp = 1;
        @(posedge clk); #1 chk("R7 drop on suspend", {7'b0, stall}, 8'h00);
        @(negedge clk); susp = 0; done = 1; err = 1; busy = 0;
        @(negedge clk); done = 0; err = 0;
        bus_rd(0, v); chk("R8 error result", v, 8'h13);
    endtask

    task automatic t_mode_a();
        do_reset();
        bus_wr(0, 8'h00); bus_wr(0, 8'h01);
        @(negedge clk); busy = 1;
        @(negedge clk); @(negedge clk);
        chk("R6 no stall in mode A", {7'b0, stall}, 8'h00);
        @(negedge clk); busy = 0; done = 1;
        @(negedge clk); done = 0;
    endtask

    task automatic t_exit();
        logic [7:0] v;
        do_reset(); enter_b();
        @(negedge clk); busy = 1;
        @(negedge clk);
        chk("R9 stall before clear", {7'b0, stall}, 8'h01);
        bus_wr(0, 8'h00);
        chk("R9 stall cleared", {6'b0, stall, mode_b}, 8'h00);
        busy = 0;
        bus_rd(0, v); chk("R9 msel cleared", v & 8'h03, 8'h00);
    endtask

    task automatic t_id();
        logic [7:0] v;
        do_reset();
        bus_wr(2, 8'hFF); bus_rd(2, v); chk("R10 id readback", v, 8'h03);
        bus_wr(2, 8'hFF); bus_rd(0, v); bus_rd(2, v); chk("R10 read elsewhere clears", v, 8'h00);
        bus_wr(2, 8'hFF); bus_wr(1, 8'h00); bus_rd(2, v); chk("R10 write elsewhere clears", v, 8'h00);
        bus_wr(2, 8'h7F); bus_rd(2, v); chk("R10 non-key write", v, 8'h00);
    endtask

    initial begin
        t_reset();
        t_arming();
        t_disarm();
        t_status();
        t_stall();
        t_mode_a();
        t_exit();
        t_id();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog actual hung expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule